// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a memory-mapped timer that raises a level interrupt at a fixed, programmable rate. The input clock is first divided by sixteen. Each divided tick advances a 20-bit current-value counter. The counter returns to zero after it reaches the programmed period. Every return to zero adds one to a 12-bit interval counter and sets a status flag. While the interrupt enable is also set, the status flag drives the interrupt line.

Software reads the two counters in one of two ways. A read at offset 0x08 takes the count and acknowledges it: the interval count returns to zero and the status flag is lowered. A read at offset 0x0C returns the same word and changes nothing. Clearing the enable bit does not stop the timer at once. The counter runs on to its next return to zero and then rests there. This lets software stop the timer cleanly on a period boundary.

The bus is simple. Address, write strobe and write data are sampled on the clock edge, and read data appears one cycle after the read strobe.

Top module: `pit_timer`

## Requirements
- R1: After a synchronous reset, every register reads zero, the timer is stopped and `irq` is low.
- R2: The mode register at offset 0x00 keeps bit 25 (interrupt enable), bit 24 (timer enable) and bits 19:0 (period). A read of it returns those bits and zero in all other positions.
- R3: While the timer runs, the current value advances by exactly one every 16 clock cycles. Between ticks it does not change.
- R4: On a tick where the current value is equal to or above the period, the current value becomes zero, the interval count increases by one and status bit 0 (offset 0x04) is set. So one full period lasts period+1 ticks.
- R5: The interval count wraps from 4095 to 0 when it is not cleared.
- R6: A read at offset 0x08 returns the interval count in bits 31:20 and the current value in bits 19:0. The returned word holds the values from before the read. The read then sets the interval count to zero and clears the status flag.
- R7: A read at offset 0x0C returns the same fields as R6 and changes no state.
- R8: `irq` is high exactly when the status flag and the interrupt enable are both set.
- R9: After the timer enable is cleared, the counter keeps ticking until it returns to zero. It then holds at zero.
- R10: When a wrap and a read at 0x08 fall in the same cycle, the wrap wins. The interval count becomes 1 and the status flag stays set.
- R11: The status register is read-only. Writes to offsets other than 0x00 change nothing. Reads of unmapped offsets return zero.
- R12: `bus_rdata` shows the addressed word in the cycle after `bus_rd` is high, and shows zero in the cycle after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
The timer is run with three periods. A period of 1023 shows the sixteen-cycle step of the divider without any wraps getting in the way. A period of 3 gives frequent wraps, so interrupt set, clear and acknowledge can all be seen. A period of 0 gives a wrap on every tick, which runs the interval count through its modulo-4096 rollover in reasonable time.

A clearing read is placed on the exact cycle of a wrap to separate "wrap wins" from "clear wins". The enable is dropped in mid-period to show that the counter coasts on to zero instead of halting where it stands. Writes to read-only and unmapped offsets are then followed by reads of the mode and status words.

// File: rtl/pit_pkg.sv
package pit_pkg;
  localparam int unsigned OFS_MODE = 32'h00;
  localparam int unsigned OFS_STAT = 32'h04;
  localparam int unsigned OFS_VAL  = 32'h08;
  localparam int unsigned OFS_IMG  = 32'h0C;
  localparam int unsigned IEN_BIT  = 25;
  localparam int unsigned EN_BIT   = 24;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MODE,
    SEL_STAT,
    SEL_VAL,
    SEL_IMG
  } reg_sel_e;
endpackage

// File: rtl/pit_prescale.sv
module pit_prescale #(
  parameter int DIV_LOG2 = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  logic [DIV_LOG2-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || !run) pre_q <= '0;
    else             pre_q <= pre_q + 1'b1;
  end

  assign tick = run && (pre_q == {DIV_LOG2{1'b1}});

  p_idle_clears_r3: assert property (@(posedge clk) disable iff (rst)
    !run |=> (pre_q == '0));
  p_tick_spaced_r3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

// File: rtl/pit_count.sv
module pit_count #(
  parameter int CNT_W  = 20,
  parameter int ICNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              clr,
  input  logic [CNT_W-1:0]  period,
  output logic [CNT_W-1:0]  cur_q,
  output logic [ICNT_W-1:0] icnt_q,
  output logic              stat_q,
  output logic              stat_d
);
  logic [CNT_W-1:0]  cur_d;
  logic [ICNT_W-1:0] icnt_d;
  logic              wrap;

  assign wrap = tick && (cur_q >= period);

  always_comb begin
    cur_d  = cur_q;
    icnt_d = icnt_q;
    stat_d = stat_q;
    if (clr) begin
      icnt_d = '0;
      stat_d = 1'b0;
    end
    if (wrap) begin
      cur_d  = '0;
      icnt_d = icnt_d + 1'b1;
      stat_d = 1'b1;
    end else if (tick) begin
      cur_d = cur_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= '0;
      icnt_q <= '0;
      stat_q <= 1'b0;
    end else begin
      cur_q  <= cur_d;
      icnt_q <= icnt_d;
      stat_q <= stat_d;
    end
  end

  p_hold_no_tick_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(cur_q));
  p_wrap_sets_r4: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (stat_q && cur_q == '0));
  p_icnt_step_r5: assert property (@(posedge clk) disable iff (rst)
    (wrap && !clr) |=> (icnt_q == ICNT_W'($past(icnt_q) + 1'b1)));
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (clr && !wrap) |=> (icnt_q == '0 && !stat_q));
  p_wrap_wins_r10: assert property (@(posedge clk) disable iff (rst)
    (clr && wrap) |=> (icnt_q == ICNT_W'(1) && stat_q));
endmodule

// File: rtl/pit_regs.sv
module pit_regs
  import pit_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 20,
  parameter int ICNT_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd,
  input  logic [CNT_W-1:0]  cur,
  input  logic [ICNT_W-1:0] icnt,
  input  logic              stat_q,
  input  logic              stat_d,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic              en,
  output logic [CNT_W-1:0]  period,
  output logic              clr
);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(OFS_MODE);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_VAL  = ADDR_W'(OFS_VAL);
  localparam logic [ADDR_W-1:0] A_IMG  = ADDR_W'(OFS_IMG);

  reg_sel_e          sel;
  logic              ien_q, ien_d, en_d;
  logic [CNT_W-1:0]  per_d;
  logic [DATA_W-1:0] rmux;
  logic              mode_wr;

  always_comb begin
    unique case (addr)
      A_MODE:  sel = SEL_MODE;
      A_STAT:  sel = SEL_STAT;
      A_VAL:   sel = SEL_VAL;
      A_IMG:   sel = SEL_IMG;
      default: sel = SEL_NONE;
    endcase
  end

  assign mode_wr = wr && (sel == SEL_MODE);
  assign clr     = rd && (sel == SEL_VAL);
  assign ien_d   = mode_wr ? wdata[IEN_BIT] : ien_q;
  assign en_d    = mode_wr ? wdata[EN_BIT]  : en;
  assign per_d   = mode_wr ? wdata[CNT_W-1:0] : period;

  always_comb begin
    rmux = '0;
    case (sel)
      SEL_MODE: begin
        rmux[IEN_BIT]     = ien_q;
        rmux[EN_BIT]      = en;
        rmux[CNT_W-1:0]   = period;
      end
      SEL_STAT: rmux[0] = stat_q;
      SEL_VAL, SEL_IMG: rmux[CNT_W+ICNT_W-1:0] = {icnt, cur};
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q  <= 1'b0;
      en     <= 1'b0;
      period <= '0;
      rdata  <= '0;
      irq    <= 1'b0;
    end else begin
      ien_q  <= ien_d;
      en     <= en_d;
      period <= per_d;
      rdata  <= rd ? rmux : '0;
      irq    <= stat_d && ien_d;
    end
  end

  p_irq_level_r8: assert property (@(posedge clk) disable iff (rst)
    irq == (stat_q && ien_q));
  p_unmapped_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (rd && sel == SEL_NONE) |=> (rdata == '0));
  p_mode_kept_r11: assert property (@(posedge clk) disable iff (rst)
    !mode_wr |=> ($stable(period) && $stable(en) && $stable(ien_q)));
  p_idle_rdata_r12: assert property (@(posedge clk) disable iff (rst)
    !rd |=> (rdata == '0));
endmodule

// File: rtl/pit_timer.sv
module pit_timer #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CNT_W    = 20,
  parameter int ICNT_W   = 12,
  parameter int DIV_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic              en, run, tick, clr, stat_q, stat_d;
  logic [CNT_W-1:0]  period, cur;
  logic [ICNT_W-1:0] icnt;

  assign run = en || (cur != '0);

  pit_prescale #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst(rst), .run(run), .tick(tick)
  );

  pit_count #(.CNT_W(CNT_W), .ICNT_W(ICNT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .clr(clr), .period(period),
    .cur_q(cur), .icnt_q(icnt), .stat_q(stat_q), .stat_d(stat_d)
  );

  pit_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .ICNT_W(ICNT_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .rd(bus_rd), .cur(cur), .icnt(icnt), .stat_q(stat_q), .stat_d(stat_d),
    .rdata(bus_rdata), .irq(irq), .en(en), .period(period), .clr(clr)
  );

  p_stop_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (!en && cur == '0) |=> (cur == '0));
endmodule

// File: tb/test_pit_timer.sv
module test_pit_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq;

  int    checks = 0;
  int    errors = 0;
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;
  string phase = "R1";

  // reference state
  int          m_pre;
  logic [19:0] m_cur, m_per;
  logic [11:0] m_cnt;
  logic        m_st, m_en, m_ien, m_irq;
  logic [31:0] m_rd;

  always #2 clk = ~clk;

  pit_timer i_pit_timer (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    bit act, tk;
    logic [31:0] v;
    logic [19:0] n_cur;
    logic [11:0] n_cnt;
    logic n_st;
    if (rst) begin
      m_pre = 0; m_cur = 0; m_per = 0; m_cnt = 0;
      m_st = 0; m_en = 0; m_ien = 0; m_irq = 0; m_rd = 0;
    end else begin
      act = m_en || (m_cur != 0);
      tk  = act && (m_pre == 15);
      case (bus_addr)
        8'h00: v = {6'd0, m_ien, m_en, 4'd0, m_per};
        8'h04: v = {31'd0, m_st};
        8'h08, 8'h0C: v = {m_cnt, m_cur};
        default: v = 0;
      endcase
      n_cur = m_cur; n_cnt = m_cnt; n_st = m_st;
      if (bus_rd && bus_addr == 8'h08) begin n_cnt = 0; n_st = 0; end
      if (tk) begin
        if (m_cur >= m_per) begin n_cur = 0; n_cnt = n_cnt + 1; n_st = 1; end
        else n_cur = m_cur + 1;
      end
      m_rd  = bus_rd ? v : 32'd0;
      m_pre = act ? (m_pre + 1) % 16 : 0;
      m_cur = n_cur; m_cnt = n_cnt; m_st = n_st;
      if (bus_wr && bus_addr == 8'h00) begin
        m_ien = bus_wdata[25]; m_en = bus_wdata[24]; m_per = bus_wdata[19:0];
      end
      m_irq = m_st && m_ien;
    end
  end

  task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check(phase, bus_rdata === m_rd, bus_rdata, m_rd);
      check(phase, irq === m_irq, {31'd0, irq}, {31'd0, m_irq});
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] a, b;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    cmp_on = 1'b1;

    phase = "R1";
    rd(8'h00, a); check("R1", a == 0, a, 0);
    rd(8'h04, a); check("R1", a == 0, a, 0);
    rd(8'h08, a); check("R1", a == 0, a, 0);
    rd(8'h0C, a); check("R1", a == 0, a, 0);
    check("R1", irq == 1'b0, {31'd0, irq}, 0);

    phase = "R2";
    wr(8'h00, 32'hFCF0_0005);
    rd(8'h00, a); check("R2", a == 32'h0000_0005, a, 32'h0000_0005);

    phase = "R3";
    wr(8'h00, 32'h0100_03FF);
    idle_ticks(40);
    rd(8'h0C, a);
    repeat (15) @(negedge clk);
    rd(8'h0C, b);
    check("R3", b[19:0] == a[19:0] + 20'd1, b, a + 1);

    phase = "R4";
    wr(8'h00, 32'h0300_0003);
    rd(8'h08, a);
    repeat (200) @(negedge clk);
    rd(8'h04, a); check("R4", a == 1, a, 1);
    check("R8", irq == 1'b1, {31'd0, irq}, 1);

    phase = "R6";
    while (m_pre != 0) @(negedge clk);
    rd(8'h08, a); check("R6", a[31:20] != 0, a, 32'h0010_0000);
    rd(8'h0C, a); check("R6", a[31:20] == 0, a, {12'd0, a[19:0]});
    rd(8'h04, a); check("R6", a == 0, a, 0);
    check("R8", irq == 1'b0, {31'd0, irq}, 0);

    phase = "R7";
    repeat (150) @(negedge clk);
    while (m_pre != 0) @(negedge clk);
    rd(8'h0C, a);
    rd(8'h0C, b); check("R7", a == b, b, a);
    rd(8'h04, a); check("R7", a == 1, a, 1);

    phase = "R8";
    wr(8'h00, 32'h0100_0003);
    @(negedge clk);
    check("R8", irq == 1'b0, {31'd0, irq}, 0);
    wr(8'h00, 32'h0300_0003);
    @(negedge clk);
    check("R8", irq == 1'b1, {31'd0, irq}, 1);

    phase = "R10";
    @(negedge clk);
    while (!(m_pre == 15 && m_cur >= m_per)) @(negedge clk);
    bus_addr = 8'h08; bus_rd = 1'b1;
    @(negedge clk); bus_rd = 1'b0;
    rd(8'h0C, a); check("R10", a[31:20] == 12'd1, a, {12'd1, a[19:0]});
    rd(8'h04, a); check("R10", a == 1, a, 1);

    phase = "R5";
    wr(8'h00, 32'h0100_0000);
    rd(8'h08, a);
    repeat (4100 * 16) @(negedge clk);
    rd(8'h0C, a);
    check("R5", a[31:20] != 0 && a[31:20] < 12'd16, a, 32'h0040_0000);

    phase = "R9";
    wr(8'h00, 32'h0100_0007);
    rd(8'h08, a);
    while (!(m_cur == 20'd2 && m_pre == 0)) @(negedge clk);
    wr(8'h00, 32'h0000_0007);
    rd(8'h0C, a); check("R9", a[19:0] != 0, a, 32'h0000_0002);
    repeat (200) @(negedge clk);
    rd(8'h0C, a); check("R9", a[19:0] == 0, a, {a[31:20], 20'd0});
    repeat (100) @(negedge clk);
    rd(8'h0C, b); check("R9", b == a, b, a);
    rd(8'h04, a); check("R9", a == 1, a, 1);

    phase = "R11";
    wr(8'h04, 32'hFFFF_FFFF);
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h00, a); check("R11", a == 32'h0000_0007, a, 32'h0000_0007);
    rd(8'h04, a); check("R11", a == 1, a, 1);
    rd(8'h10, a); check("R11", a == 0, a, 0);
    rd(8'h07, a); check("R11", a == 0, a, 0);

    phase = "R12";
    rd(8'h00, a);
    @(negedge clk);
    check("R12", bus_rdata == 0, bus_rdata, 0);

    repeat (4) @(negedge clk);
    finish_run();
  end

  task automatic idle_ticks(input int n);
    repeat (n) @(negedge clk);
  endtask
endmodule